// File: doc/BRIEF.md
# Run-Ahead Prefetch Filter and Request Queue

During speculative run-ahead past a stalled load, the core produces candidate line addresses that it would like fetched early. This block screens each candidate and queues the worthwhile ones toward memory. Several requests can then be in flight together, instead of each miss being serviced after the one before it. A candidate is never allowed to stall the speculative thread. If it cannot be used, it is dropped and the drop is counted.

Each valid candidate gets exactly one outcome. The block checks three conditions in a fixed priority:

1. **Invalid address.** The address was derived from a register marked invalid.
2. **Redundant.** The line is already being fetched by an outstanding miss, or it already waits in the queue. The miss-status interface reports outstanding lines as a valid bit and a line address per slot. Clearing a slot's valid bit retires that line.
3. **Full.** The queue already holds its eight entries.

A candidate that passes all three checks is queued and counted as issued. The queue is first-in first-out and drains over a valid/ready request port. Four saturating 16-bit counters record the outcomes, and a synchronous clear input zeroes them.

The queue occupancy is tracked by a three-state machine:

| State | Meaning |
|---|---|
| `Q_EMPTY` | No entry is queued. |
| `Q_PARTIAL` | Between one and seven entries are queued. |
| `Q_FULL` | All eight entries are queued. |

Its transitions are:

| Transition | From | To | Condition |
|---|---|---|---|
| `first_push` | `Q_EMPTY` | `Q_PARTIAL` | An entry is pushed. |
| `fill` | `Q_PARTIAL` | `Q_FULL` | A push without a pop while seven entries are held. |
| `drain_last` | `Q_PARTIAL` | `Q_EMPTY` | A pop without a push while one entry is held. |
| `unfill` | `Q_FULL` | `Q_PARTIAL` | A pop. |

Every other combination keeps the current state.

Top module: `pf_filter_queue`

## Requirements
- R1: A valid candidate with its invalid flag set is never queued and increments only the invalid-drop counter. This holds even when the candidate's line also matches an outstanding or queued line, and even when the queue is full.
- R2: A valid candidate with a clear invalid flag is dropped as redundant when its line equals the line of any miss-status slot whose valid bit is set. A slot whose valid bit is clear does not cause a match.
- R3: A valid candidate with a clear invalid flag whose line equals a line currently held in the queue is dropped as redundant.
- R4: The queue holds eight entries. A non-redundant, valid-address candidate that arrives while eight are held is dropped, increments the full-drop counter and leaves the queue contents unchanged.
- R5: Fullness is judged on the occupancy at the start of the cycle. A candidate arriving in a cycle where the queue is full and an entry is popped is still dropped as full.
- R6: Queued lines leave in arrival order. An entry leaves only in a cycle where `req_valid` and `req_ready` are both high. While `req_ready` is low, `req_line` holds its value.
- R7: After reset, `req_valid` is low and all four counters read zero.
- R8: Each counter saturates at 65535 and stays there while further outcomes of its kind arrive.
- R9: A high `cnt_clr` zeroes all four counters at the next clock edge, taking priority over any increment in that cycle.
- R10: Each valid candidate increments exactly one counter. A cycle without a valid candidate increments none.
- R11: An accepted candidate is counted as issued, and it is presented on `req_line` with `req_valid` high one clock edge after acceptance if the queue was empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_clr | input | 1 | Synchronous clear of all outcome counters |
| cand_valid | input | 1 | Candidate strobe, one candidate per cycle |
| cand_line | input | ADDR_W | Candidate line address |
| cand_inv | input | 1 | Candidate address derived from an invalid register |
| mshr_valid | input | MSHR_N | Per-slot valid bit of outstanding line fetches; clearing it retires the line |
| mshr_line | input | MSHR_N*ADDR_W | Packed line addresses of outstanding fetches, slot 0 in the low bits |
| req_valid | output | 1 | Prefetch request available |
| req_ready | input | 1 | Memory side accepts the request |
| req_line | output | ADDR_W | Line address of the head request |
| cnt_issued | output | CNT_W | Candidates queued |
| cnt_full | output | CNT_W | Candidates dropped because the queue was full |
| cnt_inv | output | CNT_W | Candidates dropped because the address was invalid |
| cnt_redund | output | CNT_W | Candidates dropped as redundant |

## Verification
Every result of this block is registered exactly once: counter updates, queue pushes and pops all appear one clock edge after the cycle whose inputs caused them. The bench changes inputs on the falling edge and reads outputs on the following falling edge, half a period after the single rising edge that commits them. The one multi-cycle check is the stall case, where the head line is compared across several idle edges. The saturation run keeps the strobe high for more edges than the counter range and reads the result on the falling edge after the last one.

// File: rtl/pf_pkg.sv
package pf_pkg;
    typedef enum logic [2:0] {
        OC_NONE,
        OC_ISSUE,
        OC_FULL,
        OC_INV,
        OC_REDUND
    } outcome_e;

    typedef enum logic [1:0] {
        Q_EMPTY,
        Q_PARTIAL,
        Q_FULL
    } qstate_e;

    localparam int unsigned IDX_ISSUE  = 0;
    localparam int unsigned IDX_FULL   = 1;
    localparam int unsigned IDX_INV    = 2;
    localparam int unsigned IDX_REDUND = 3;
    localparam int unsigned N_OUTCOME  = 4;
endpackage

// File: rtl/pf_classify.sv
module pf_classify
    import pf_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned MSHR_N = 4,
    parameter int unsigned DEPTH  = 8
) (
    input  logic                     cand_valid,
    input  logic                     cand_inv,
    input  logic [ADDR_W-1:0]        cand_line,
    input  logic [MSHR_N-1:0]        mshr_valid,
    input  logic [MSHR_N*ADDR_W-1:0] mshr_line,
    input  logic [DEPTH-1:0]         q_vld,
    input  logic [DEPTH*ADDR_W-1:0]  q_lines,
    input  logic                     q_full,
    output outcome_e                 outcome
);
    logic [MSHR_N-1:0] mshr_hit;
    logic [DEPTH-1:0]  queue_hit;

    for (genvar m = 0; m < MSHR_N; m++) begin : g_mshr_cmp
        assign mshr_hit[m] = mshr_valid[m] &&
                             (mshr_line[m*ADDR_W +: ADDR_W] == cand_line);
    end

    for (genvar q = 0; q < DEPTH; q++) begin : g_queue_cmp
        assign queue_hit[q] = q_vld[q] &&
                              (q_lines[q*ADDR_W +: ADDR_W] == cand_line);
    end

    always_comb begin
        if (!cand_valid)
            outcome = OC_NONE;
        else if (cand_inv)
            outcome = OC_INV;
        else if (|mshr_hit || |queue_hit)
            outcome = OC_REDUND;
        else if (q_full)
            outcome = OC_FULL;
        else
            outcome = OC_ISSUE;
    end
endmodule

// File: rtl/pf_req_fifo.sv
module pf_req_fifo
    import pf_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned DEPTH  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    push,
    input  logic [ADDR_W-1:0]       push_line,
    input  logic                    pop,
    output logic                    full,
    output logic                    not_empty,
    output logic [ADDR_W-1:0]       head_line,
    output logic [DEPTH-1:0]        q_vld,
    output logic [DEPTH*ADDR_W-1:0] q_lines
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned OCC_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(DEPTH - 1);
    localparam logic [OCC_W-1:0] NEAR_FULL = OCC_W'(DEPTH - 1);
    localparam logic [OCC_W-1:0] ONE_LEFT  = OCC_W'(1);

    qstate_e            state, state_nxt;
    logic [ADDR_W-1:0]  slots [DEPTH];
    logic [DEPTH-1:0]   slot_vld;
    logic [PTR_W-1:0]   wr_ptr, rd_ptr;
    logic [OCC_W-1:0]   occ;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= Q_EMPTY;
        else
            state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            Q_EMPTY:   if (push) state_nxt = Q_PARTIAL;
            Q_PARTIAL: begin
                if (push && !pop && occ == NEAR_FULL)
                    state_nxt = Q_FULL;
                else if (pop && !push && occ == ONE_LEFT)
                    state_nxt = Q_EMPTY;
            end
            Q_FULL:    if (pop) state_nxt = Q_PARTIAL;
            default:   state_nxt = Q_EMPTY;
        endcase
    end

    always_comb begin
        full      = (state == Q_FULL);
        not_empty = (state != Q_EMPTY);
        head_line = slots[rd_ptr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            occ      <= '0;
            slot_vld <= '0;
        end else begin
            if (push)
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (pop)
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)
                occ <= occ + 1'b1;
            else if (pop && !push)
                occ <= occ - 1'b1;
            for (int i = 0; i < DEPTH; i++) begin
                if (push && wr_ptr == PTR_W'(i))
                    slot_vld[i] <= 1'b1;
                else if (pop && rd_ptr == PTR_W'(i))
                    slot_vld[i] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push)
            slots[wr_ptr] <= push_line;
    end

    for (genvar s = 0; s < DEPTH; s++) begin : g_flat
        assign q_lines[s*ADDR_W +: ADDR_W] = slots[s];
    end
    assign q_vld = slot_vld;
endmodule

// File: rtl/pf_outcome_counters.sv
module pf_outcome_counters #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned N     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [N-1:0]       inc,
    output logic [N*CNT_W-1:0] cnt_flat
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    for (genvar k = 0; k < N; k++) begin : g_cnt
        logic [CNT_W-1:0] value;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                value <= '0;
            else if (clr)
                value <= '0;
            else if (inc[k] && value != CNT_MAX)
                value <= value + 1'b1;
        end
        assign cnt_flat[k*CNT_W +: CNT_W] = value;
    end
endmodule

// File: rtl/pf_filter_queue.sv
module pf_filter_queue
    import pf_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned MSHR_N = 4,
    parameter int unsigned DEPTH  = 8,
    parameter int unsigned CNT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cnt_clr,
    input  logic                     cand_valid,
    input  logic [ADDR_W-1:0]        cand_line,
    input  logic                     cand_inv,
    input  logic [MSHR_N-1:0]        mshr_valid,
    input  logic [MSHR_N*ADDR_W-1:0] mshr_line,
    output logic                     req_valid,
    input  logic                     req_ready,
    output logic [ADDR_W-1:0]        req_line,
    output logic [CNT_W-1:0]         cnt_issued,
    output logic [CNT_W-1:0]         cnt_full,
    output logic [CNT_W-1:0]         cnt_inv,
    output logic [CNT_W-1:0]         cnt_redund
);
    outcome_e                  outcome;
    logic                      q_full;
    logic [DEPTH-1:0]          q_vld;
    logic [DEPTH*ADDR_W-1:0]   q_lines;
    logic                      do_push, do_pop;
    logic [N_OUTCOME-1:0]      inc;
    logic [N_OUTCOME*CNT_W-1:0] cnt_flat;

    pf_classify #(.ADDR_W(ADDR_W), .MSHR_N(MSHR_N), .DEPTH(DEPTH)) u_cls (
        .cand_valid (cand_valid),
        .cand_inv   (cand_inv),
        .cand_line  (cand_line),
        .mshr_valid (mshr_valid),
        .mshr_line  (mshr_line),
        .q_vld      (q_vld),
        .q_lines    (q_lines),
        .q_full     (q_full),
        .outcome    (outcome)
    );

    always_comb begin
        do_push          = (outcome == OC_ISSUE);
        do_pop           = req_valid && req_ready;
        inc              = '0;
        inc[IDX_ISSUE]   = (outcome == OC_ISSUE);
        inc[IDX_FULL]    = (outcome == OC_FULL);
        inc[IDX_INV]     = (outcome == OC_INV);
        inc[IDX_REDUND]  = (outcome == OC_REDUND);
    end

    pf_req_fifo #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .push_line (cand_line),
        .pop       (do_pop),
        .full      (q_full),
        .not_empty (req_valid),
        .head_line (req_line),
        .q_vld     (q_vld),
        .q_lines   (q_lines)
    );

    pf_outcome_counters #(.CNT_W(CNT_W), .N(N_OUTCOME)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .inc      (inc),
        .cnt_flat (cnt_flat)
    );

    assign cnt_issued = cnt_flat[IDX_ISSUE*CNT_W  +: CNT_W];
    assign cnt_full   = cnt_flat[IDX_FULL*CNT_W   +: CNT_W];
    assign cnt_inv    = cnt_flat[IDX_INV*CNT_W    +: CNT_W];
    assign cnt_redund = cnt_flat[IDX_REDUND*CNT_W +: CNT_W];
endmodule

// File: rtl/pf_filter_queue_chk.sv
module pf_filter_queue_chk #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cnt_clr,
    input logic              cand_valid,
    input logic              cand_inv,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_line,
    input logic [CNT_W-1:0]  cnt_issued,
    input logic [CNT_W-1:0]  cnt_full,
    input logic [CNT_W-1:0]  cnt_inv,
    input logic [CNT_W-1:0]  cnt_redund
);
    localparam logic [CNT_W-1:0] TOP = '1;

    // R1
    inv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && cand_inv && !cnt_clr && cnt_inv != TOP)
        |=> (cnt_inv == $past(cnt_inv) + 1'b1) && $stable(cnt_issued));

    // R6
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_line)));

    // R8
    inv_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_inv == TOP && !cnt_clr) |=> (cnt_inv == TOP));

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (cnt_issued == '0 && cnt_full == '0 &&
                     cnt_inv == '0 && cnt_redund == '0));

    // R10
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> ($countones({cnt_issued != $past(cnt_issued),
                                  cnt_full   != $past(cnt_full),
                                  cnt_inv    != $past(cnt_inv),
                                  cnt_redund != $past(cnt_redund)}) <= 1));

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cand_valid && !cnt_clr) |=> ($stable(cnt_issued) && $stable(cnt_full) &&
                                       $stable(cnt_inv) && $stable(cnt_redund)));
endmodule

bind pf_filter_queue pf_filter_queue_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_clr    (cnt_clr),
    .cand_valid (cand_valid),
    .cand_inv   (cand_inv),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_line   (req_line),
    .cnt_issued (cnt_issued),
    .cnt_full   (cnt_full),
    .cnt_inv    (cnt_inv),
    .cnt_redund (cnt_redund)
);

// File: tb/sim_pf_filter_queue.sv
module sim_pf_filter_queue;
    localparam int ADDR_W = 32;
    localparam int MSHR_N = 4;
    localparam int CNT_W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_clr = 1'b0;
    logic cand_valid = 1'b0;
    logic [ADDR_W-1:0] cand_line = '0;
    logic cand_inv = 1'b0;
    logic [MSHR_N-1:0] mshr_valid = '0;
    logic [MSHR_N*ADDR_W-1:0] mshr_line = '0;
    logic req_valid;
    logic req_ready = 1'b0;
    logic [ADDR_W-1:0] req_line;
    logic [CNT_W-1:0] cnt_issued, cnt_full, cnt_inv, cnt_redund;

    int n_chk = 0;
    int n_err = 0;
    int e_iss = 0, e_full = 0, e_inv = 0, e_red = 0;

    always #4 clk = ~clk;

    pf_filter_queue u0 (
        .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr),
        .cand_valid(cand_valid), .cand_line(cand_line), .cand_inv(cand_inv),
        .mshr_valid(mshr_valid), .mshr_line(mshr_line),
        .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line),
        .cnt_issued(cnt_issued), .cnt_full(cnt_full),
        .cnt_inv(cnt_inv), .cnt_redund(cnt_redund)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_counts(input string req);
        chk(req, "cnt_issued", 32'(cnt_issued), 32'(e_iss));
        chk(req, "cnt_full",   32'(cnt_full),   32'(e_full));
        chk(req, "cnt_inv",    32'(cnt_inv),    32'(e_inv));
        chk(req, "cnt_redund", 32'(cnt_redund), 32'(e_red));
    endtask

    task automatic drive_cand(input logic [31:0] line, input logic inv);
        @(negedge clk);
        cand_valid = 1'b1;
        cand_line  = line;
        cand_inv   = inv;
        @(negedge clk);
        cand_valid = 1'b0;
        cand_inv   = 1'b0;
    endtask

    task automatic t_reset();
        chk("R7", "req_valid", 32'(req_valid), 32'd0);
        chk_counts("R7");
    endtask

    task automatic t_invalid();
        drive_cand(32'h100, 1'b1);
        e_inv++;
        chk("R1", "req_valid", 32'(req_valid), 32'd0);
        chk_counts("R1");
        mshr_line[0 +: ADDR_W] = 32'h100;
        mshr_valid[0] = 1'b1;
        drive_cand(32'h100, 1'b1);
        e_inv++;
        chk_counts("R1");
        @(negedge clk);
        chk_counts("R10");
    endtask

    task automatic t_mshr();
        mshr_line[ADDR_W +: ADDR_W] = 32'h200;
        mshr_valid[1] = 1'b1;
        drive_cand(32'h200, 1'b0);
        e_red++;
        chk("R2", "req_valid", 32'(req_valid), 32'd0);
        chk_counts("R2");
        mshr_valid = '0;
        drive_cand(32'h200, 1'b0);
        e_iss++;
        chk("R11", "req_valid", 32'(req_valid), 32'd1);
        chk("R11", "req_line", req_line, 32'h200);
        chk_counts("R11");
    endtask

    task automatic t_queue_dup();
        drive_cand(32'h200, 1'b0);
        e_red++;
        chk_counts("R3");
    endtask

    task automatic t_full();
        for (int i = 0; i < 7; i++) begin
            drive_cand(32'h300 + 32'(i), 1'b0);
            e_iss++;
        end
        chk_counts("R4");
        drive_cand(32'h400, 1'b0);
        e_full++;
        chk_counts("R4");
        drive_cand(32'h200, 1'b1);
        e_inv++;
        chk_counts("R1");
        repeat (3) @(negedge clk);
        chk("R6", "stalled head", req_line, 32'h200);
        @(negedge clk);
        cand_valid = 1'b1;
        cand_line  = 32'h500;
        req_ready  = 1'b1;
        @(negedge clk);
        cand_valid = 1'b0;
        e_full++;
        chk_counts("R5");
        for (int i = 0; i < 7; i++) begin
            chk("R6", "req_valid", 32'(req_valid), 32'd1);
            chk("R6", "order", req_line, 32'h300 + 32'(i));
            @(negedge clk);
        end
        chk("R4", "drained queue", 32'(req_valid), 32'd0);
        req_ready = 1'b0;
    endtask

    task automatic t_clear();
        @(negedge clk);
        cand_valid = 1'b1;
        cand_line  = 32'h600;
        cnt_clr    = 1'b1;
        @(negedge clk);
        cand_valid = 1'b0;
        cnt_clr    = 1'b0;
        e_iss = 0; e_full = 0; e_inv = 0; e_red = 0;
        chk_counts("R9");
        chk("R11", "req_line", req_line, 32'h600);
    endtask

    task automatic t_saturate();
        @(negedge clk);
        cand_valid = 1'b1;
        cand_line  = 32'h700;
        cand_inv   = 1'b1;
        repeat (65540) @(negedge clk);
        cand_valid = 1'b0;
        cand_inv   = 1'b0;
        e_inv = 65535;
        chk_counts("R8");
        drive_cand(32'h700, 1'b1);
        chk_counts("R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_invalid();
        mshr_valid = '0;
        t_mshr();
        t_queue_dup();
        t_full();
        t_clear();
        t_saturate();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule